// File: doc/BRIEF.md
# UART Register Bank with Interrupt Control

This block sits on a simple synchronous register bus and holds the software-visible state of a small serial port. The state is a receive buffer, a transmit holding byte, interrupt enable and identification bytes, line control, modem control, line status, modem status and a divisor. Every register is eight bits wide at a word-aligned offset. Writing the transmit holding byte hands a character to an external transmitter through a valid/ready offer. The transmitter later pulses a done strobe. The character is trimmed to the word length set in line control. An external receiver delivers bytes with a one-cycle valid strobe. The block keeps the holding-empty and receive-ready flags and drives one level interrupt line.

Transmit sequencing is a small state machine with three states. TX_IDLE waits for a holding write (transition IDLE→OFFER). TX_OFFER presents the character until the transmitter takes it (OFFER→FLIGHT on ready). TX_FLIGHT waits for the done strobe. That strobe leads either back to TX_IDLE with a completion event (FLIGHT→IDLE) or, if a newer byte was written meanwhile, straight to TX_OFFER with no completion (FLIGHT→OFFER). Modem control, modem status and the divisor are plain storage. A divisor of zero means no pacing.

Top module: `uart_regbank`

## Requirements
- R1: After reset the line status register reads 0x20, every other register reads 0x00, `irq` is low and `tx_valid` is low.
- R2: The register index is address bits [4:2]. Index 0 reads the receive buffer and writes the transmit holding byte. Indices 1 to 7 are, in order, interrupt enable, interrupt identification, line control, modem control, line status, modem status and divisor. Writes keep `bus_wdata[7:0]`, and reads return the byte zero-extended to 32 bits.
- R3: An access with address bits [1:0] not zero, or with address bits above [4:0] set, raises `bus_err` in that cycle, reads as zero and changes no register.
- R4: A write to index 0 stores the byte. It clears line status bit 5 and identification bit 1, and on the next cycle `tx_valid` is high.
- R5: `tx_valid` stays high until a cycle with `tx_ready`. It then stays low until `tx_done`. A holding write during flight is offered right after `tx_done`, with bit 5 staying clear, and every written byte reaches the transmitter in write order.
- R6: Line control bits [1:0] set the word length (00=5, 01=6, 10=7, 11=8 bits). `tx_data` is the held byte ANDed with 0x1F, 0x3F, 0x7F or 0xFF to match.
- R7: A completion sets line status bit 5 and loads identification with 0x02. It raises `irq` when enable bit 1 is set, and leaves `irq` as it was otherwise.
- R8: Writing enable with bit 1 set while status bit 5 is set sets identification bit 1 and raises `irq` on the next cycle. Writing enable with bit 1 clear drops `irq`.
- R9: A cycle with `rx_valid` latches `rx_data` into the receive buffer and sets status bit 0. With enable bit 0 set, it also loads identification with 0x04 and raises `irq`. With bit 0 clear, identification and `irq` are left as they were.
- R10: Reading index 0 clears status bit 0, unless a byte arrives in the same cycle, in which case bit 0 stays set and the new byte is kept.
- R11: When a completion and a byte arrival fall in the same cycle, both status bits end up set. Identification reads 0x04 when the receive interrupt is enabled, and `irq` rises if either event is enabled. Hardware events take precedence over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access to an unmapped offset |
| tx_valid | output | 1 | Character offered to the transmitter |
| tx_data | output | 8 | Offered character, length-masked |
| tx_ready | input | 1 | Transmitter takes the offered character |
| tx_done | input | 1 | Transmitter finished the character in flight |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request, level |

## Verification
Two events can land in the same cycle: a transmit completion from `tx_done`, and a byte arrival from `rx_valid`. Both also touch the identification byte and the interrupt line. The bench pulses both strobes together with both interrupts enabled. It then expects identification 0x04, status 0x21 and `irq` high. A second collision drives a receive-buffer read together with a new arrival, and the ready flag must survive. In a third, a holding write lands in flight, and the done strobe must lead to a fresh offer rather than a completion.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int REG_W = 8;
    localparam int NUM_REGS = 8;
    localparam int IDX_W = $clog2(NUM_REGS);

    // register index = address bits [4:2]; order matters to software
    typedef enum logic [2:0] {
        RG_DATA  = 3'd0,
        RG_IEN   = 3'd1,
        RG_IID   = 3'd2,
        RG_LCTL  = 3'd3,
        RG_MCTL  = 3'd4,
        RG_LSTAT = 3'd5,
        RG_MSTAT = 3'd6,
        RG_DIV   = 3'd7
    } reg_idx_e;

    localparam int IEN_RX_BIT = 0;
    localparam int IEN_TX_BIT = 1;
    localparam int LS_RX_BIT  = 0;
    localparam int LS_TX_BIT  = 5;

    localparam logic [REG_W-1:0] IID_TX_CODE = 8'h02;
    localparam logic [REG_W-1:0] IID_RX_CODE = 8'h04;
    localparam logic [REG_W-1:0] LS_RESET    = 8'h20;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_OFFER,
        TX_FLIGHT
    } tx_state_e;

    function automatic logic [REG_W-1:0] word_mask(input logic [1:0] len);
        logic [REG_W-1:0] m;
        unique case (len)
            2'b00: m = 8'h1F;
            2'b01: m = 8'h3F;
            2'b10: m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              mapped,
    output logic              err
);
    logic upper_clear;

    generate
        if (ADDR_W > 5) begin : g_wide
            assign upper_clear = (bus_addr[ADDR_W-1:5] == '0);
        end else begin : g_narrow
            assign upper_clear = 1'b1;
        end
    endgenerate

    assign reg_idx = bus_addr[4:2];
    assign mapped  = upper_clear && (bus_addr[1:0] == 2'b00);
    assign err     = bus_sel && !mapped;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
            assign wr_hit[g] = bus_sel && mapped &&  bus_we && (reg_idx == IDX_W'(g));
            assign rd_hit[g] = bus_sel && mapped && !bus_we && (reg_idx == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_wr,
    input  logic xmit_ready,
    input  logic xmit_done,
    output logic offer,
    output logic complete
);
    tx_state_e state_q, state_n;
    logic      pend_q, pend_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        pend_n  = pend_q;
        unique case (state_q)
            TX_IDLE: begin
                if (hold_wr) state_n = TX_OFFER;
            end
            TX_OFFER: begin
                if (xmit_ready) begin
                    state_n = TX_FLIGHT;
                    pend_n  = hold_wr;
                end
            end
            TX_FLIGHT: begin
                if (xmit_done) begin
                    state_n = (pend_q || hold_wr) ? TX_OFFER : TX_IDLE;
                    pend_n  = 1'b0;
                end else if (hold_wr) begin
                    pend_n = 1'b1;
                end
            end
            default: begin
                state_n = TX_IDLE;
                pend_n  = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        offer    = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            TX_IDLE:   ;
            TX_OFFER:  offer = 1'b1;
            TX_FLIGHT: complete = xmit_done && !pend_q && !hold_wr;
            default:   ;
        endcase
    end

endmodule

// File: rtl/uart_rx_capture.sv
module uart_rx_capture
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [REG_W-1:0] rx_data,
    output logic [REG_W-1:0] rbr,
    output logic             arrive
);
    always_ff @(posedge clk) begin
        if (!rst_n)        rbr <= '0;
        else if (rx_valid) rbr <= rx_data;
    end

    assign arrive = rx_valid;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              irq
);
    logic [NUM_REGS-1:0] wr_hit, rd_hit;
    logic [IDX_W-1:0]    reg_idx;
    logic                mapped;
    logic                tx_complete, rx_arrive;
    logic [REG_W-1:0]    wbyte;
    logic [REG_W-1:0]    rbr_q;

    logic [REG_W-1:0] thr_q, ier_q, iir_q, lcr_q, mcr_q, lsr_q, msr_q, div_q;
    logic [REG_W-1:0] iir_n, lsr_n;
    logic             irq_q, irq_n;
    logic [REG_W-1:0] rd_byte;

    assign wbyte = bus_wdata[REG_W-1:0];

    uart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .reg_idx (reg_idx),
        .mapped  (mapped),
        .err     (bus_err)
    );

    uart_tx_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_wr   (wr_hit[RG_DATA]),
        .xmit_ready(tx_ready),
        .xmit_done (tx_done),
        .offer     (tx_valid),
        .complete  (tx_complete)
    );

    uart_rx_capture u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rbr     (rbr_q),
        .arrive  (rx_arrive)
    );

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
            ier_q <= '0;
            lcr_q <= '0;
            mcr_q <= '0;
            msr_q <= '0;
            div_q <= '0;
        end else begin
            if (wr_hit[RG_DATA])  thr_q <= wbyte;
            if (wr_hit[RG_IEN])   ier_q <= wbyte;
            if (wr_hit[RG_LCTL])  lcr_q <= wbyte;
            if (wr_hit[RG_MCTL])  mcr_q <= wbyte;
            if (wr_hit[RG_MSTAT]) msr_q <= wbyte;
            if (wr_hit[RG_DIV])   div_q <= wbyte;
        end
    end

    // status, identification and interrupt: bus first, hardware events last
    always_comb begin
        lsr_n = lsr_q;
        iir_n = iir_q;
        irq_n = irq_q;

        if (wr_hit[RG_LSTAT]) lsr_n = wbyte;
        if (wr_hit[RG_IID])   iir_n = wbyte;

        if (wr_hit[RG_DATA]) begin
            lsr_n[LS_TX_BIT]  = 1'b0;
            iir_n[IEN_TX_BIT] = 1'b0;
        end
        if (rd_hit[RG_DATA]) lsr_n[LS_RX_BIT] = 1'b0;

        if (wr_hit[RG_IEN]) begin
            if (!wbyte[IEN_TX_BIT]) begin
                irq_n = 1'b0;
            end else if (lsr_q[LS_TX_BIT]) begin
                iir_n[IEN_TX_BIT] = 1'b1;
                irq_n = 1'b1;
            end
        end

        if (tx_complete) begin
            lsr_n[LS_TX_BIT] = 1'b1;
            iir_n = IID_TX_CODE;
            if (ier_q[IEN_TX_BIT]) irq_n = 1'b1;
        end

        if (rx_arrive) begin
            lsr_n[LS_RX_BIT] = 1'b1;
            if (ier_q[IEN_RX_BIT]) begin
                iir_n = IID_RX_CODE;
                irq_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsr_q <= LS_RESET;
            iir_q <= '0;
            irq_q <= 1'b0;
        end else begin
            lsr_q <= lsr_n;
            iir_q <= iir_n;
            irq_q <= irq_n;
        end
    end

    // read mux
    always_comb begin
        rd_byte = '0;
        if (bus_sel && mapped && !bus_we) begin
            unique case (reg_idx_e'(reg_idx))
                RG_DATA:  rd_byte = rbr_q;
                RG_IEN:   rd_byte = ier_q;
                RG_IID:   rd_byte = iir_q;
                RG_LCTL:  rd_byte = lcr_q;
                RG_MCTL:  rd_byte = mcr_q;
                RG_LSTAT: rd_byte = lsr_q;
                RG_MSTAT: rd_byte = msr_q;
                RG_DIV:   rd_byte = div_q;
                default:  rd_byte = '0;
            endcase
        end
    end

    assign bus_rdata = {{(DATA_W-REG_W){1'b0}}, rd_byte};
    assign tx_data   = thr_q & word_mask(lcr_q[1:0]);
    assign irq       = irq_q;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_err,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              tx_done,
    input logic              rx_valid,
    input logic              irq,
    input logic [7:0]        lsr,
    input logic [7:0]        lcr,
    input logic [7:0]        ier,
    input logic [7:0]        mcr,
    input logic [7:0]        msr,
    input logic [7:0]        div
);
    logic bus_wr_ok;
    assign bus_wr_ok = bus_sel && bus_we && !bus_err;

    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable({ier, lcr, mcr, msr, div}));

    a_r4_hold_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_ok && bus_addr == ADDR_W'(0)) |=> !lsr[LS_TX_BIT]);

    a_r5_offer_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    a_r6_char_masked: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_data & ~word_mask(lcr[1:0])) == 8'h00));

    a_r8_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_ok && bus_addr == ADDR_W'(4) && !bus_wdata[IEN_TX_BIT]
         && !rx_valid && !tx_done) |=> !irq);

    a_r9_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> lsr[LS_RX_BIT]);

endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_err  (bus_err),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .rx_valid (rx_valid),
    .irq      (irq),
    .lsr      (lsr_q),
    .lcr      (lcr_q),
    .ier      (ier_q),
    .mcr      (mcr_q),
    .msr      (msr_q),
    .div      (div_q)
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0, tx_done = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a,
                          input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, $sformatf("read @%h", a), bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver: write the holding byte and queue what the transmitter must see
    task automatic send(input logic [7:0] d, input logic [7:0] exp);
        exp_q.push_back(exp);
        bus_wr(5'h00, {24'hFFFFFF, d});
        chk("R4", "tx_valid after hold write", tx_valid, 1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic finish_tx();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // monitor: compare every character the transmitter takes
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk("R5", "unexpected character", {24'h0, tx_data}, 32'hXX);
            end else begin
                chk("R6", "transmitted character", {24'h0, tx_data},
                    {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "irq", irq, 0);
        chk("R1", "tx_valid", tx_valid, 0);
        for (int i = 0; i < 8; i++)
            rd_chk("R1", 5'(i * 4), (i == 5) ? 32'h20 : 32'h0);

        // R2 storage registers, upper bits dropped
        bus_wr(5'h10, 32'hDEAD_BE5A);
        bus_wr(5'h18, 32'h0000_01C3);
        bus_wr(5'h1C, 32'hABCD_1234);
        rd_chk("R2", 5'h10, 32'h5A);
        rd_chk("R2", 5'h18, 32'hC3);
        rd_chk("R2", 5'h1C, 32'h34);
        bus_wr(5'h0C, 32'h3);
        rd_chk("R2", 5'h0C, 32'h3);

        // R3 unmapped offsets
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h0E; #1;
        chk("R3", "bus_err on unaligned read", bus_err, 1);
        chk("R3", "rdata on unaligned read", bus_rdata, 0);
        @(negedge clk);
        bus_sel = 1'b0; #1;
        chk("R3", "bus_err idle", bus_err, 0);
        bus_wr(5'h0D, 32'hFF);
        bus_wr(5'h01, 32'h55);
        chk("R3", "no transmit from unaligned write", tx_valid, 0);
        rd_chk("R3", 5'h0C, 32'h3);
        rd_chk("R3", 5'h14, 32'h20);

        // R4/R5/R7 single character, interrupts off
        exp_q.push_back(8'hA5);
        bus_wr(5'h00, 32'hA5);
        chk("R4", "tx_valid", tx_valid, 1);
        rd_chk("R4", 5'h14, 32'h00);
        chk("R5", "offer held without ready", tx_valid, 1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R5", "offer dropped in flight", tx_valid, 0);
        finish_tx();
        rd_chk("R7", 5'h14, 32'h20);
        rd_chk("R7", 5'h08, 32'h02);
        chk("R7", "irq stays low when disabled", irq, 0);

        // R6 word-length masking
        bus_wr(5'h0C, 32'h0); send(8'hFF, 8'h1F); finish_tx();
        bus_wr(5'h0C, 32'h1); send(8'hFF, 8'h3F); finish_tx();
        bus_wr(5'h0C, 32'h2); send(8'hFF, 8'h7F); finish_tx();
        bus_wr(5'h0C, 32'h3);

        // R8 enable with holding empty
        bus_wr(5'h08, 32'h0);
        bus_wr(5'h04, 32'h2);
        chk("R8", "irq raised on enable", irq, 1);
        rd_chk("R8", 5'h08, 32'h02);
        bus_wr(5'h04, 32'h0);
        chk("R8", "irq dropped on disable", irq, 0);
        bus_wr(5'h04, 32'h2);
        bus_wr(5'h08, 32'h0);
        send(8'h3E, 8'h3E);
        rd_chk("R4", 5'h08, 32'h00);
        bus_wr(5'h04, 32'h0);
        bus_wr(5'h04, 32'h2);
        chk("R8", "busy enable leaves irq low", irq, 0);
        finish_tx();
        chk("R7", "irq on completion", irq, 1);
        rd_chk("R7", 5'h08, 32'h02);
        bus_wr(5'h04, 32'h0);

        // R5 write during flight is queued
        send(8'h11, 8'h11);
        exp_q.push_back(8'h22);
        bus_wr(5'h00, 32'h22);
        chk("R5", "no offer while in flight", tx_valid, 0);
        finish_tx();
        chk("R5", "queued offer after done", tx_valid, 1);
        rd_chk("R5", 5'h14, 32'h00);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        finish_tx();
        rd_chk("R5", 5'h14, 32'h20);

        // R9/R10 receive
        bus_wr(5'h08, 32'h0);
        rx_push(8'h5A);
        rd_chk("R9", 5'h14, 32'h21);
        rd_chk("R9", 5'h08, 32'h00);
        chk("R9", "irq low with rx disabled", irq, 0);
        rd_chk("R10", 5'h00, 32'h5A);
        rd_chk("R10", 5'h14, 32'h20);
        bus_wr(5'h04, 32'h1);
        rx_push(8'h3C);
        chk("R9", "irq on arrival", irq, 1);
        rd_chk("R9", 5'h08, 32'h04);
        rd_chk("R9", 5'h00, 32'h3C);

        // R11 completion and arrival in one cycle
        bus_wr(5'h04, 32'h3);
        bus_wr(5'h08, 32'h0);
        send(8'h77, 8'h77);
        @(negedge clk);
        tx_done = 1'b1; rx_valid = 1'b1; rx_data = 8'h81;
        @(negedge clk);
        tx_done = 1'b0; rx_valid = 1'b0;
        chk("R11", "irq", irq, 1);
        rd_chk("R11", 5'h08, 32'h04);
        rd_chk("R11", 5'h14, 32'h21);

        // R10 buffer read with same-cycle arrival
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h00;
        rx_valid = 1'b1; rx_data = 8'h42; #1;
        chk("R10", "old byte read", bus_rdata, 32'h81);
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        rd_chk("R10", 5'h14, 32'h21);
        rd_chk("R10", 5'h00, 32'h42);
        rd_chk("R10", 5'h14, 32'h20);

        // R11 hardware wins over a same-cycle status write
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h14; bus_wdata = 32'h0;
        rx_valid = 1'b1; rx_data = 8'h09;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
        rd_chk("R11", 5'h14, 32'h01);

        repeat (4) @(negedge clk);
        chk("R5", "all characters delivered", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule